// File: doc/BRIEF.md
# Character-Row CRT Timing Generator

This block generates raster timing for a character-cell display adapter. A character clock advances a horizontal counter that marks out scanlines. Scanlines are grouped into character rows of programmable height, and rows are grouped into a frame. An optional run of extra scanlines can follow the last row. The block drives horizontal sync, vertical sync and display-enable. It also produces a linear memory address and the scanline-within-row index, which a display memory uses as its upper address bits. A character height of 2 or 4 therefore splits the memory into 2 or 4 interleaved banks.

Software programs the block through a byte-wide write port and polls a two-bit status output to find where the beam is. The vertical registers and the start address take effect only when a frame wraps. Software can therefore write the next frame's geometry while the current frame is still running, and stack short frames of different heights. For example, a 127-line frame followed by a 135-line frame gives the 262 lines a 15.7 kHz / 60 Hz monitor expects, even with one scanline per row. The horizontal registers act at once.

Top module: `crtc_timing`

## Requirements
- R1: A scanline lasts line_total+1 character clocks. The horizontal counter runs from 0 up to line_total and then restarts at 0.
- R2: A frame holds rows_total+1 character rows. The row counter is 7 bits wide, so a frame has at most 128 rows. The frame lasts (rows_total+1)*(char_height+1)+adjust scanlines.
- R3: After the last scanline of the last row, the block inserts adjust scanlines, where adjust is 0 to 31. During these scanlines the row index output counts 0 up to adjust-1 and display is off.
- R4: Each row lasts char_height+1 scanlines. During a row the row index output counts 0 up to char_height. A char_height of 0 gives one scanline per row.
- R5: Display-enable is high when the horizontal count is below line_shown, the row is below rows_shown, and the block is not in the adjust period.
- R6: Horizontal sync is high for the hsync_width characters that start at horizontal count hsync_at. It ends early if the line ends first. A width of 0 gives no pulse.
- R7: The sync counter starts in the first scanline of row vsync_row, where vsync_row is 0 or at most rows_total. Vertical sync then lasts 16 scanlines, and it continues across a frame end if it reaches one. With the default polarity the pin is high during sync.
- R8: Writes to rows_total, rows_shown, vsync_row, adjust, char_height or the start address made during a frame change nothing until that frame wraps.
- R9: The memory address is the row base plus the horizontal count, modulo 2^14. The row base loads the start address at frame start. It grows by line_shown after the last scanline of every row, the last row included.
- R10: The status output carries the sync-active state in bit 1 and display-enable in bit 0. Bit 1 ignores the pin polarity.
- R11: Register select codes are: 0 line_total, 1 line_shown, 2 hsync_at, 3 hsync_width (bits 3:0), 4 rows_total, 5 adjust, 6 rows_shown, 7 vsync_row, 8 char_height, 9 start address bits 13:8, 10 start address bits 7:0. Reset clears every register and every counter. While reset is held, all outputs are low.
- R12: Two stacked frames of 127 and 135 scanlines repeat every 262 scanlines, measured from one sync start to the sync start two frames later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select code |
| wr_data | input | 8 | Register write value |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, polarity set by parameter |
| de | output | 1 | Display-enable |
| ma | output | 14 | Linear character memory address |
| ra | output | 5 | Scanline within row (or adjust index) |
| stat | output | 2 | Status: {sync active, display-enable} |

## Verification
Two things can happen in the same character clock. A frame can wrap, which reloads the geometry and the start address. In that same clock, vertical sync can either start (sync row 0) or still be running from the previous frame. The bench provokes both. It stacks a 135-line frame whose sync begins 15 lines before its end in front of a 127-line frame, and it runs a one-row frame whose sync row is 0, so that the sync starts exactly at the wrap. A cycle-by-cycle arithmetic model judges each case. The model derives the row, the scanline, the address and the sync from the line number inside the frame, and it switches geometry only at its own frame boundary.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
   localparam logic [3:0] SEL_LTOT   = 4'd0;
   localparam logic [3:0] SEL_LSHOW  = 4'd1;
   localparam logic [3:0] SEL_HSAT   = 4'd2;
   localparam logic [3:0] SEL_HSWID  = 4'd3;
   localparam logic [3:0] SEL_RTOT   = 4'd4;
   localparam logic [3:0] SEL_ADJ    = 4'd5;
   localparam logic [3:0] SEL_RSHOW  = 4'd6;
   localparam logic [3:0] SEL_VSROW  = 4'd7;
   localparam logic [3:0] SEL_CHT    = 4'd8;
   localparam logic [3:0] SEL_BASEHI = 4'd9;
   localparam logic [3:0] SEL_BASELO = 4'd10;
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
   import crtc_pkg::*;
#(
   parameter int HCW  = 8,
   parameter int RCW  = 7,
   parameter int SCW  = 5,
   parameter int MAW  = 14,
   parameter int HSWW = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [3:0]      wr_sel,
   input  logic [7:0]      wr_data,
   output logic [HCW-1:0]  ltot,
   output logic [HCW-1:0]  lshow,
   output logic [HCW-1:0]  hs_at,
   output logic [HSWW-1:0] hs_wid,
   output logic [RCW-1:0]  rtot,
   output logic [RCW-1:0]  rshow,
   output logic [RCW-1:0]  vs_row,
   output logic [SCW-1:0]  adj,
   output logic [SCW-1:0]  cht,
   output logic [MAW-1:0]  base
);
   localparam int HIW = MAW - 8;

   logic [HIW-1:0] base_hi;
   logic [7:0]     base_lo;

   always_ff @(posedge clk) begin
      if (rst) begin
         ltot    <= '0;
         lshow   <= '0;
         hs_at   <= '0;
         hs_wid  <= '0;
         rtot    <= '0;
         rshow   <= '0;
         vs_row  <= '0;
         adj     <= '0;
         cht     <= '0;
         base_hi <= '0;
         base_lo <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_LTOT:   ltot    <= wr_data[HCW-1:0];
            SEL_LSHOW:  lshow   <= wr_data[HCW-1:0];
            SEL_HSAT:   hs_at   <= wr_data[HCW-1:0];
            SEL_HSWID:  hs_wid  <= wr_data[HSWW-1:0];
            SEL_RTOT:   rtot    <= wr_data[RCW-1:0];
            SEL_ADJ:    adj     <= wr_data[SCW-1:0];
            SEL_RSHOW:  rshow   <= wr_data[RCW-1:0];
            SEL_VSROW:  vs_row  <= wr_data[RCW-1:0];
            SEL_CHT:    cht     <= wr_data[SCW-1:0];
            SEL_BASEHI: base_hi <= wr_data[HIW-1:0];
            SEL_BASELO: base_lo <= wr_data;
            default: ;
         endcase
      end
   end

   assign base = {base_hi, base_lo};
endmodule

// File: rtl/crtc_hctr.sv
module crtc_hctr #(
   parameter int HCW  = 8,
   parameter int HSWW = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [HCW-1:0]  ltot,
   input  logic [HCW-1:0]  lshow,
   input  logic [HCW-1:0]  hs_at,
   input  logic [HSWW-1:0] hs_wid,
   output logic [HCW-1:0]  hcnt,
   output logic            line_end,
   output logic            hde,
   output logic            hsync
);
   logic [HCW:0] hoff;

   assign line_end = (hcnt >= ltot);
   assign hde      = (hcnt < lshow);
   assign hoff     = {1'b0, hcnt} - {1'b0, hs_at};
   assign hsync    = (hcnt >= hs_at) && (hoff < (HCW+1)'(hs_wid));

   always_ff @(posedge clk) begin
      if (rst)           hcnt <= '0;
      else if (line_end) hcnt <= '0;
      else               hcnt <= hcnt + 1'b1;
   end

   a_r1_line_restart: assert property (@(posedge clk) disable iff (rst)
      line_end |=> (hcnt == '0));
   a_r6_zero_width: assert property (@(posedge clk) disable iff (rst)
      (hs_wid == '0) |-> !hsync);
endmodule

// File: rtl/crtc_vctr.sv
module crtc_vctr #(
   parameter int HCW      = 8,
   parameter int RCW      = 7,
   parameter int SCW      = 5,
   parameter int MAW      = 14,
   parameter int VS_LINES = 16
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           line_end,
   input  logic [HCW-1:0] lshow,
   input  logic [RCW-1:0] rtot_p,
   input  logic [RCW-1:0] rshow_p,
   input  logic [RCW-1:0] vs_row_p,
   input  logic [SCW-1:0] adj_p,
   input  logic [SCW-1:0] cht_p,
   input  logic [MAW-1:0] base_p,
   output logic           vde,
   output logic           vs_on,
   output logic [MAW-1:0] row_base,
   output logic [SCW-1:0] ra
);
   localparam int VSW = $clog2(VS_LINES + 1);

   logic [RCW-1:0] rtot_a, rshow_a, vs_row_a, row;
   logic [SCW-1:0] adj_a, cht_a, sl, adj_cnt;
   logic           in_adj;
   logic [VSW-1:0] vs_cnt;
   logic           row_end, last_row, wrap, to_adj, row_step, vs_start;

   assign row_end  = line_end && !in_adj && (sl == cht_a);
   assign last_row = (row == rtot_a);
   assign wrap     = (line_end && in_adj && (adj_cnt == SCW'(adj_a - 1'b1)))
                   || (row_end && last_row && (adj_a == '0));
   assign to_adj   = row_end && last_row && (adj_a != '0);
   assign row_step = row_end && !last_row;
   assign vs_start = (row_step && (RCW'(row + 1'b1) == vs_row_a))
                   || (wrap && (vs_row_p == '0));

   always_ff @(posedge clk) begin
      if (rst) begin
         row <= '0; sl <= '0; adj_cnt <= '0; in_adj <= 1'b0;
         rtot_a <= '0; rshow_a <= '0; vs_row_a <= '0; adj_a <= '0; cht_a <= '0;
         row_base <= '0;
      end else if (wrap) begin
         row <= '0; sl <= '0; adj_cnt <= '0; in_adj <= 1'b0;
         rtot_a   <= rtot_p;
         rshow_a  <= rshow_p;
         vs_row_a <= vs_row_p;
         adj_a    <= adj_p;
         cht_a    <= cht_p;
         row_base <= base_p;
      end else if (to_adj) begin
         in_adj   <= 1'b1;
         adj_cnt  <= '0;
         sl       <= '0;
         row_base <= row_base + MAW'(lshow);
      end else if (row_step) begin
         row      <= row + 1'b1;
         sl       <= '0;
         row_base <= row_base + MAW'(lshow);
      end else if (line_end) begin
         if (in_adj) adj_cnt <= adj_cnt + 1'b1;
         else        sl      <= sl + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                            vs_cnt <= '0;
      else if (vs_start)                  vs_cnt <= VSW'(VS_LINES);
      else if (line_end && vs_cnt != '0)  vs_cnt <= vs_cnt - 1'b1;
   end

   assign vde   = !in_adj && (row < rshow_a);
   assign vs_on = (vs_cnt != '0);
   assign ra    = in_adj ? adj_cnt : sl;

   a_r2_row_bound: assert property (@(posedge clk) disable iff (rst)
      !in_adj |-> (row <= rtot_a));
   a_r3_adj_bound: assert property (@(posedge clk) disable iff (rst)
      in_adj |-> (adj_cnt < adj_a));
   a_r4_scan_bound: assert property (@(posedge clk) disable iff (rst)
      sl <= cht_a);
   a_r7_sync_len: assert property (@(posedge clk) disable iff (rst)
      vs_cnt <= VSW'(VS_LINES));
   a_r8_hold_frame: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> ($stable(rtot_a) && $stable(vs_row_a) && $stable(cht_a) && $stable(adj_a)));
   a_r9_base_load: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (row_base == $past(base_p)));
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing #(
   parameter int HCW        = 8,
   parameter int RCW        = 7,
   parameter int SCW        = 5,
   parameter int MAW        = 14,
   parameter int HSWW       = 4,
   parameter int VS_LINES   = 16,
   parameter bit VS_POS_POL = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           wr_en,
   input  logic [3:0]     wr_sel,
   input  logic [7:0]     wr_data,
   output logic           hsync,
   output logic           vsync,
   output logic           de,
   output logic [MAW-1:0] ma,
   output logic [SCW-1:0] ra,
   output logic [1:0]     stat
);
   if (HCW < 4 || HCW > 8) begin : g_bad_hcw
      $error("HCW must lie in 4..8");
   end
   if (RCW < 2 || RCW > 8) begin : g_bad_rcw
      $error("RCW must lie in 2..8");
   end
   if (SCW < 1 || SCW > 8) begin : g_bad_scw
      $error("SCW must lie in 1..8");
   end
   if (MAW < 9 || MAW > 16) begin : g_bad_maw
      $error("MAW must lie in 9..16");
   end
   if (HSWW < 1 || HSWW > 8) begin : g_bad_hsww
      $error("HSWW must lie in 1..8");
   end
   if (VS_LINES < 1) begin : g_bad_vsl
      $error("VS_LINES must be positive");
   end

   logic [HCW-1:0]  ltot, lshow, hs_at, hcnt;
   logic [HSWW-1:0] hs_wid;
   logic [RCW-1:0]  rtot, rshow, vs_row;
   logic [SCW-1:0]  adj, cht;
   logic [MAW-1:0]  base, row_base;
   logic            line_end, hde, vde, vs_on;

   crtc_regs #(.HCW(HCW), .RCW(RCW), .SCW(SCW), .MAW(MAW), .HSWW(HSWW)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ltot(ltot), .lshow(lshow), .hs_at(hs_at), .hs_wid(hs_wid),
      .rtot(rtot), .rshow(rshow), .vs_row(vs_row), .adj(adj), .cht(cht), .base(base)
   );

   crtc_hctr #(.HCW(HCW), .HSWW(HSWW)) u_hctr (
      .clk(clk), .rst(rst), .ltot(ltot), .lshow(lshow), .hs_at(hs_at), .hs_wid(hs_wid),
      .hcnt(hcnt), .line_end(line_end), .hde(hde), .hsync(hsync)
   );

   crtc_vctr #(.HCW(HCW), .RCW(RCW), .SCW(SCW), .MAW(MAW), .VS_LINES(VS_LINES)) u_vctr (
      .clk(clk), .rst(rst), .line_end(line_end), .lshow(lshow),
      .rtot_p(rtot), .rshow_p(rshow), .vs_row_p(vs_row), .adj_p(adj), .cht_p(cht),
      .base_p(base), .vde(vde), .vs_on(vs_on), .row_base(row_base), .ra(ra)
   );

   assign de   = hde && vde;
   assign ma   = row_base + MAW'(hcnt);
   assign stat = {vs_on, de};

   if (VS_POS_POL) begin : g_vs_high
      assign vsync = vs_on;
   end else begin : g_vs_low
      assign vsync = ~vs_on;
   end

   a_r5_de_needs_row: assert property (@(posedge clk) disable iff (rst)
      de |-> (ra <= SCW'({SCW{1'b1}})) && vde);
   a_r10_stat_vs: assert property (@(posedge clk) disable iff (rst)
      $rose(stat[1]) |-> (ma == row_base));
endmodule

// File: tb/crtc_timing_bench.sv
module crtc_timing_bench;
   localparam int MAW = 14;

   typedef struct packed {
      int htot; int hdisp; int hsat; int hswid;
      int vtot; int vadj;  int vdisp; int vsrow; int ms; int start;
   } cfg_t;

   logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
   logic [3:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic        hsync, vsync, de;
   logic [13:0] ma;
   logic [4:0]  ra;
   logic [1:0]  stat;

   crtc_timing u_crtc_timing (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .hsync(hsync), .vsync(vsync), .de(de), .ma(ma), .ra(ra), .stat(stat)
   );

   always #10 clk = ~clk;

   int   total = 0, bad = 0;
   cfg_t cur, pend, c1, cA, cB, c2, c3;
   int   ln, hc, vsl, cyc;
   bit   flip;
   int   q_sel[8], q_dat[8];
   int   qn = 0, qi = 0;

   task automatic chk(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int flen(cfg_t c);
      return (c.vtot + 1) * (c.ms + 1) + c.vadj;
   endfunction

   task automatic check_cycle();
      int h, act, base, e_ra, e_vde, e_de, e_hs, e_vs;
      h   = cur.ms + 1;
      act = (cur.vtot + 1) * h;
      if (ln < act) begin
         e_ra  = ln % h;
         e_vde = ((ln / h) < cur.vdisp) ? 1 : 0;
         base  = cur.start + (ln / h) * cur.hdisp;
      end else begin
         e_ra  = ln - act;
         e_vde = 0;
         base  = cur.start + (cur.vtot + 1) * cur.hdisp;
      end
      e_de = (e_vde == 1 && hc < cur.hdisp) ? 1 : 0;
      e_hs = (hc >= cur.hsat && (hc - cur.hsat) < cur.hswid) ? 1 : 0;
      e_vs = (vsl > 0) ? 1 : 0;
      chk("R5", "de", int'(de), e_de);
      chk("R6", "hsync", int'(hsync), e_hs);
      chk("R7", "vsync", int'(vsync), e_vs);
      chk("R9", "ma", int'(ma), (base + hc) % (1 << MAW));
      chk((ln < act) ? "R4" : "R3", "ra", int'(ra), e_ra);
      chk("R10", "stat", int'(stat), e_vs * 2 + e_de);
   endtask

   task automatic adv();
      hc++;
      if (hc > cur.htot) begin
         hc = 0;
         if (vsl > 0) vsl--;
         ln++;
         if (ln == flen(cur)) begin
            ln  = 0;
            cur = pend;
         end
         if (cur.vsrow <= cur.vtot && ln == cur.vsrow * (cur.ms + 1)) vsl = 16;
      end
   endtask

   task automatic wr(int sel, int val);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_sel = 4'(sel); wr_data = 8'(val);
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic program_all(cfg_t c);
      wr(4, c.vtot); wr(5, c.vadj); wr(6, c.vdisp); wr(7, c.vsrow); wr(8, c.ms);
      wr(9, c.start >> 8); wr(10, c.start & 255);
      wr(1, c.hdisp); wr(2, c.hsat); wr(3, c.hswid); wr(0, c.htot);
   endtask

   task automatic push_vert(cfg_t c);
      q_sel[0] = 4; q_dat[0] = c.vtot;
      q_sel[1] = 5; q_dat[1] = c.vadj;
      q_sel[2] = 6; q_dat[2] = c.vdisp;
      q_sel[3] = 7; q_dat[3] = c.vsrow;
      q_sel[4] = 8; q_dat[4] = c.ms;
      q_sel[5] = 9; q_dat[5] = c.start >> 8;
      q_sel[6] = 10; q_dat[6] = c.start & 255;
      qn = 7; qi = 0;
      pend = c;
   endtask

   task automatic anchor(cfg_t c);
      int  rises;
      logic prev;
      rises = 0;
      prev  = vsync;
      while (rises < 2) begin
         @(posedge clk); #1;
         if (vsync && !prev) rises++;
         prev = vsync;
      end
      cur = c; pend = c;
      ln = c.vsrow * (c.ms + 1); hc = 0; vsl = 16;
      check_cycle();
   endtask

   task automatic run(int n, bit alt);
      int   rise_t[16];
      int   nr, last_hs;
      logic vs_prev, hs_prev;
      nr = 0; last_hs = -1; vs_prev = vsync; hs_prev = hsync;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         wr_en = 1'b0;
         cyc++;
         adv();
         check_cycle();
         if (alt && ln == 0 && hc == 0) begin
            chk("R8", "ma at frame start", int'(ma), cur.start % (1 << MAW));
            chk("R8", "ra at frame start", int'(ra), 0);
         end
         if (hsync && !hs_prev) begin
            if (last_hs >= 0) chk("R1", "hsync period", cyc - last_hs, cur.htot + 1);
            last_hs = cyc;
         end
         if (vsync && !vs_prev) begin
            if (!alt && nr > 0)
               chk("R2", "vsync period", cyc - rise_t[nr-1], flen(cur) * (cur.htot + 1));
            if (nr < 16) begin
               rise_t[nr] = cyc;
               nr++;
            end
         end
         hs_prev = hsync;
         vs_prev = vsync;
         if (alt && ln == 20 && hc == 0) begin
            push_vert(flip ? cB : cA);
            flip = !flip;
         end
         if (qn > 0) begin
            wr_en = 1'b1; wr_sel = 4'(q_sel[qi]); wr_data = 8'(q_dat[qi]);
            qi++;
            if (qi == qn) begin qn = 0; qi = 0; end
         end
      end
      @(posedge clk); #1;
      wr_en = 1'b0; qn = 0; qi = 0;
      if (alt) begin
         if (nr >= 3)
            chk("R12", "two-frame stack period", rise_t[nr-1] - rise_t[nr-3], 262 * (cur.htot + 1));
         else
            chk("R12", "sync starts seen", nr, 3);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cyc  = 0;
      flip = 1'b0;
      c1 = '{htot:9, hdisp:6, hsat:7, hswid:2, vtot:9, vadj:3, vdisp:8, vsrow:5, ms:2, start:'h100};
      cA = '{htot:9, hdisp:6, hsat:7, hswid:2, vtot:126, vadj:0, vdisp:100, vsrow:100, ms:0, start:'h3FF0};
      cB = '{htot:9, hdisp:6, hsat:7, hswid:2, vtot:127, vadj:7, vdisp:120, vsrow:120, ms:0, start:'h0123};
      c2 = '{htot:4, hdisp:7, hsat:0, hswid:0, vtot:5, vadj:31, vdisp:6, vsrow:1, ms:3, start:'h3FFE};
      c3 = '{htot:7, hdisp:3, hsat:5, hswid:15, vtot:0, vadj:0, vdisp:0, vsrow:0, ms:31, start:'h0055};

      // R11: outputs held low during reset
      repeat (3) @(posedge clk);
      #1;
      chk("R11", "hsync in reset", int'(hsync), 0);
      chk("R11", "vsync in reset", int'(vsync), 0);
      chk("R11", "de in reset", int'(de), 0);
      chk("R11", "ma in reset", int'(ma), 0);
      chk("R11", "ra in reset", int'(ra), 0);
      chk("R11", "stat in reset", int'(stat), 0);
      rst = 1'b0;
      // R11: cleared registers give one-char lines, one-line frames, sync row 0
      repeat (3) @(posedge clk);
      #1;
      chk("R11", "vsync after reset", int'(vsync), 1);
      chk("R11", "de after reset", int'(de), 0);
      chk("R11", "ma after reset", int'(ma), 0);
      chk("R11", "hsync after reset", int'(hsync), 0);

      // main geometry, then stacked 127/135-line frames changed mid-frame (R8, R12)
      program_all(c1);
      anchor(c1);
      run(7000, 1'b1);

      // display wider than the line, no hsync, long adjust, four scanline banks, address wrap
      program_all(c2);
      anchor(c2);
      run(1000, 1'b0);

      // one-row frame with 32 scanlines, sync row 0 at wrap, hsync cut by line end
      program_all(c3);
      anchor(c3);
      run(800, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule